// File: doc/BRIEF.md
# Soft-Decision Viterbi Decoder, Rate 1/2, Constraint Length 7

This block recovers the information bits of a rate-1/2 convolutional code with constraint length 7 (64 trellis states). Each accepted input beat carries one received symbol pair: two 3-bit soft values in offset binary plus one erasure flag per value. Higher code rates are decoded by an upstream depuncturer. It fills each removed position with any value and raises that position's erasure flag, so the same decoder serves every punctured rate at one pair per clock.

Every accepted pair advances the trellis one step. Four branch metrics are formed. Then 64 add-compare-select cells update all state metrics in the same clock. A survivor store of 42 steps per state holds each state's decoded history. Once the store is full, each new pair releases one decoded bit, oldest first, taken from the state with the smallest metric. Both sides use a valid/ready handshake.

Top module: `sd_viterbi_dec`

## Requirements
- R1: Encoder convention: the 7-bit window is {u, s}, with the new bit u at bit 6, s[5] the previous bit and s[0] the oldest. Output a is the parity of window AND 171 octal, output b is the parity of window AND 133 octal, and the next state is {u, s[5:1]}. A stream encoded this way from the zero state and sent with hard values (0 for a zero, 7 for a one) is decoded bit-exact and in order.
- R2: Soft values are offset binary, 0 meaning a certain zero and 7 a certain one. A symbol adds its value to a branch that expects 0 and adds 7 minus its value to a branch that expects 1. Weak but correctly signed values, with an isolated fully inverted symbol every 25 pairs, still decode without error.
- R3: A symbol whose erasure flag is 1 adds 0 to every branch, whatever its soft value. A stream with the b symbol of every odd-numbered pair erased and filled with random values decodes without error.
- R4: State metrics are 8-bit unsigned. When the smallest metric has its top bit set, that bit is cleared in every metric before the add. An add never saturates, and after such a step the smallest metric is below 128, so long noisy streams decode without error.
- R5: On a tie between the two incoming paths, a state keeps the path from the lower-numbered predecessor. On a tie between state metrics, the output takes the lowest-numbered state. An all-erased stream therefore decodes to all zeros.
- R6: After a synchronous active-low reset, state 0 has metric 0, every other state has metric INIT_METRIC (64), out_valid is 0 and in_ready is 1.
- R7: in_ready equals (not out_valid) or out_ready. While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_bit stays unchanged.
- R8: With a survivor depth of 42, the first decoded bit appears after the 43rd accepted pair. N accepted pairs yield exactly N-42 output bits, and nothing is emitted without input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Symbol pair offered |
| in_ready | output | 1 | Decoder can take a pair this cycle |
| in_soft_a | input | SOFT_W | Soft value of the 171-octal symbol |
| in_soft_b | input | SOFT_W | Soft value of the 133-octal symbol |
| in_erase_a | input | 1 | Symbol a erased (no metric contribution) |
| in_erase_b | input | 1 | Symbol b erased (no metric contribution) |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Sink takes the decoded bit |
| out_bit | output | 1 | Decoded information bit |

## Verification
The decoder is exercised with hard clean streams, including runs of all zeros and all ones, which isolate the trellis labelling and the zero-state start. Weak soft values with isolated inverted symbols show that distances are weighted rather than thresholded. Punctured streams with random values in the erased positions show that erased symbols really contribute nothing. A fully erased stream can only decode to zeros if both tie rules hold. A long noisy run forces repeated metric normalisation, and random sink backpressure tests the stall behaviour and output ordering.

// File: rtl/sdv_pkg.sv
`timescale 1ns/1ps
// Shared constants of the rate-1/2, constraint-length-7 code.
// Assumes state s holds the previous six input bits with the newest in s[5].
package sdv_pkg;
    localparam int MEM_BITS   = 6;
    localparam int NUM_STATES = 1 << MEM_BITS;
    localparam logic [MEM_BITS:0] POLY_A = 7'o171;
    localparam logic [MEM_BITS:0] POLY_B = 7'o133;

    // Code label {a, b} of the window {u, s}; it indexes the branch metric array.
    function automatic logic [1:0] branch_label(input logic [MEM_BITS:0] window);
        return {^(window & POLY_A), ^(window & POLY_B)};
    endfunction
endpackage

// File: rtl/sdv_branch_metric.sv
`timescale 1ns/1ps
// Forms the four branch metrics of one symbol pair, indexed by the label {a, b}.
// Assumes offset-binary soft values; an erased symbol contributes zero.
module sdv_branch_metric #(
    parameter int SOFT_W = 3,
    localparam int BM_W  = SOFT_W + 1
) (
    input  logic [SOFT_W-1:0]       soft_a,
    input  logic [SOFT_W-1:0]       soft_b,
    input  logic                    erase_a,
    input  logic                    erase_b,
    output logic [3:0][BM_W-1:0]    bm
);
    localparam logic [SOFT_W-1:0] SOFT_MAX = '1;

    logic [SOFT_W-1:0] dist_a0, dist_a1, dist_b0, dist_b1;

    // Per-symbol distance to a hypothesised 0 or 1, masked by the erasure flag.
    always_comb begin
        dist_a0 = erase_a ? '0 : soft_a;
        dist_a1 = erase_a ? '0 : SOFT_MAX - soft_a;
        dist_b0 = erase_b ? '0 : soft_b;
        dist_b1 = erase_b ? '0 : SOFT_MAX - soft_b;
    end

    for (genvar h = 0; h < 4; h++) begin : g_label
        localparam bit HYP_A = ((h / 2) % 2) == 1;
        localparam bit HYP_B = (h % 2) == 1;
        assign bm[h] = BM_W'(HYP_A ? dist_a1 : dist_a0) + BM_W'(HYP_B ? dist_b1 : dist_b0);
    end
endmodule

// File: rtl/sdv_acs_array.sv
`timescale 1ns/1ps
// Holds the 64 state metrics and runs all add-compare-select cells in parallel.
// Normalises by clearing the metric MSB when the smallest metric has it set.
// Reports the best state of the current metrics (lowest index on a tie).
module sdv_acs_array
    import sdv_pkg::*;
#(
    parameter int SOFT_W      = 3,
    parameter int PM_W        = 8,
    parameter int INIT_METRIC = 64,
    localparam int BM_W  = SOFT_W + 1,
    localparam int SUM_W = PM_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic [3:0][BM_W-1:0]     bm,
    output logic [NUM_STATES-1:0]    dec,
    output logic [MEM_BITS-1:0]      best_state,
    output logic [PM_W-1:0]          min_metric
);
    logic [PM_W-1:0] pm_q    [NUM_STATES];
    logic [PM_W-1:0] pm_eff  [NUM_STATES];
    logic [PM_W-1:0] pm_next [NUM_STATES];
    logic            norm;

    // Smallest current metric and its state, scanning upward so ties keep the lower index.
    always_comb begin
        best_state = '0;
        min_metric = pm_q[0];
        for (int i = 1; i < NUM_STATES; i++) begin
            if (pm_q[i] < min_metric) begin
                min_metric = pm_q[i];
                best_state = MEM_BITS'(i);
            end
        end
    end

    assign norm = min_metric[PM_W-1];

    // Normalised metrics feeding the adders.
    always_comb begin
        for (int i = 0; i < NUM_STATES; i++) begin
            pm_eff[i] = pm_q[i];
            if (norm) pm_eff[i][PM_W-1] = 1'b0;
        end
    end

    for (genvar n = 0; n < NUM_STATES; n++) begin : g_acs
        localparam int PRED_LO = (2 * n) % NUM_STATES;
        localparam int PRED_HI = PRED_LO + 1;
        localparam logic [MEM_BITS-1:0] ID = MEM_BITS'(n);
        localparam logic [1:0] LAB_LO = branch_label({ID, 1'b0});
        localparam logic [1:0] LAB_HI = branch_label({ID, 1'b1});

        logic [SUM_W-1:0] cand_lo, cand_hi, winner;
        logic             pick_hi;

        assign cand_lo = {1'b0, pm_eff[PRED_LO]} + SUM_W'(bm[LAB_LO]);
        assign cand_hi = {1'b0, pm_eff[PRED_HI]} + SUM_W'(bm[LAB_HI]);
        assign pick_hi = cand_hi < cand_lo;
        assign winner  = pick_hi ? cand_hi : cand_lo;
        assign dec[n]  = pick_hi;
        assign pm_next[n] = winner[PM_W] ? '1 : winner[PM_W-1:0];

        assert_no_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
            step_en |-> !winner[PM_W]);
    end

    // Metric registers: zero-state start on reset, trellis step on each accepted pair.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_STATES; i++) begin
            if (!rst_n)       pm_q[i] <= (i == 0) ? '0 : PM_W'(INIT_METRIC);
            else if (step_en) pm_q[i] <= pm_next[i];
        end
    end

    assert_norm_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && norm |=> !min_metric[PM_W-1]);

    assert_reset_metrics_R6: assert property (@(posedge clk)
        !rst_n |=> (min_metric == '0) && (best_state == '0)
                   && (pm_q[NUM_STATES-1] == PM_W'(INIT_METRIC)));
endmodule

// File: rtl/sdv_survivor.sv
`timescale 1ns/1ps
// Survivor store: each state keeps the decoded bits of its surviving path
// (register exchange). The oldest bit of the chosen state is offered as output.
// Assumes dec and best_state come from the same metric snapshot as the paths.
module sdv_survivor
    import sdv_pkg::*;
#(
    parameter int DEPTH = 42
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic [NUM_STATES-1:0]   dec,
    input  logic [MEM_BITS-1:0]     best_state,
    output logic                    oldest_bit
);
    localparam int HALF = NUM_STATES / 2;

    logic [DEPTH-1:0] path_q    [NUM_STATES];
    logic [DEPTH-1:0] path_next [NUM_STATES];

    // Append each state's own input bit to the path of its selected predecessor.
    always_comb begin
        for (int i = 0; i < NUM_STATES; i++) begin
            path_next[i] = dec[i] ? {path_q[2 * (i % HALF) + 1][DEPTH-2:0], i >= HALF}
                                  : {path_q[2 * (i % HALF)][DEPTH-2:0],     i >= HALF};
        end
    end

    // Path registers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_STATES; i++) begin
            if (!rst_n)       path_q[i] <= '0;
            else if (step_en) path_q[i] <= path_next[i];
        end
    end

    assign oldest_bit = path_q[best_state][DEPTH-1];
endmodule

// File: rtl/sd_viterbi_dec.sv
`timescale 1ns/1ps
// Soft-decision Viterbi decoder top: handshake, fill tracking and output register.
// One accepted pair is one trellis step; once DEPTH steps are stored, each step
// releases one decoded bit. The whole decoder stalls while the output is held.
module sd_viterbi_dec
    import sdv_pkg::*;
#(
    parameter int SOFT_W      = 3,
    parameter int PM_W        = 8,
    parameter int INIT_METRIC = 64,
    parameter int TB_DEPTH    = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SOFT_W-1:0] in_soft_a,
    input  logic [SOFT_W-1:0] in_soft_b,
    input  logic              in_erase_a,
    input  logic              in_erase_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_bit
);
    localparam int BM_W   = SOFT_W + 1;
    localparam int FILL_W = $clog2(TB_DEPTH + 1);

    logic [3:0][BM_W-1:0]  bm;
    logic [NUM_STATES-1:0] dec;
    logic [MEM_BITS-1:0]   best_state;
    logic [PM_W-1:0]       min_metric;
    logic                  oldest_bit;
    logic                  step;
    logic                  full;
    logic [FILL_W-1:0]     fill_q;

    assign in_ready = !out_valid || out_ready;
    assign step     = in_valid && in_ready;
    assign full     = fill_q == FILL_W'(TB_DEPTH);

    sdv_branch_metric #(.SOFT_W(SOFT_W)) u_bmu (
        .soft_a  (in_soft_a),
        .soft_b  (in_soft_b),
        .erase_a (in_erase_a),
        .erase_b (in_erase_b),
        .bm      (bm)
    );

    sdv_acs_array #(.SOFT_W(SOFT_W), .PM_W(PM_W), .INIT_METRIC(INIT_METRIC)) u_acs (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step),
        .bm         (bm),
        .dec        (dec),
        .best_state (best_state),
        .min_metric (min_metric)
    );

    sdv_survivor #(.DEPTH(TB_DEPTH)) u_surv (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step),
        .dec        (dec),
        .best_state (best_state),
        .oldest_bit (oldest_bit)
    );

    // Count stored steps until the survivor store is full.
    always_ff @(posedge clk) begin
        if (!rst_n)            fill_q <= '0;
        else if (step && !full) fill_q <= fill_q + 1'b1;
    end

    // Output register: load on a step with a full store, clear when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else if (step && full) begin
            out_valid <= 1'b1;
            out_bit   <= oldest_bit;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_hold_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_bit));

    assert_stall_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    assert_no_early_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !(step && full) |=> !out_valid);

    assert_reset_idle_R6: assert property (@(posedge clk)
        !rst_n |=> !out_valid && in_ready);
endmodule

// File: tb/test_sd_viterbi_dec.sv
`timescale 1ns/1ps
module test_sd_viterbi_dec;
    localparam int DEPTH = 42;
    localparam int MAXN  = 2100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_soft_a = '0;
    logic [2:0] in_soft_b = '0;
    logic       in_erase_a = 1'b0;
    logic       in_erase_b = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       out_bit;

    int total = 0;
    int bad   = 0;

    bit       msg   [MAXN];
    bit       expct [MAXN];
    bit [2:0] sym_a [MAXN];
    bit [2:0] sym_b [MAXN];
    bit       era_a [MAXN];
    bit       era_b [MAXN];

    always #10 clk = ~clk;

    sd_viterbi_dec i_sd_viterbi_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_soft_a  (in_soft_a),
        .in_soft_b  (in_soft_b),
        .in_erase_a (in_erase_a),
        .in_erase_b (in_erase_b),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_bit    (out_bit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference encoder output pair {a, b} for input u in state s.
    function automatic bit [1:0] enc_pair(input bit u, input bit [5:0] s);
        bit [6:0] w;
        w = {u, s};
        return {^(w & 7'o171), ^(w & 7'o133)};
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode: 0 clean random, 1 noisy, 2 punctured, 3 all erased, 4 zeros, 5 ones
    task automatic run_case(input string req, input int n, input int mode, input bit bp);
        bit [5:0] st;
        bit [1:0] cw;
        int sent, got, errs, stall_bad, first_at, cyc, first_bad;
        st = '0;
        for (int i = 0; i < n; i++) begin
            case (mode)
                4:       msg[i] = 1'b0;
                5:       msg[i] = 1'b1;
                default: msg[i] = 1'($urandom % 2);
            endcase
            cw = enc_pair(msg[i], st);
            st = {msg[i], st[5:1]};
            sym_a[i] = cw[1] ? 3'd7 : 3'd0;
            sym_b[i] = cw[0] ? 3'd7 : 3'd0;
            era_a[i] = 1'b0;
            era_b[i] = 1'b0;
            if (mode == 1) begin
                sym_a[i] = cw[1] ? 3'(5 + $urandom % 3) : 3'($urandom % 3);
                sym_b[i] = cw[0] ? 3'(5 + $urandom % 3) : 3'($urandom % 3);
                if (i % 25 == 12) sym_a[i] = cw[1] ? 3'd0 : 3'd7;
            end
            if (mode == 2 && (i % 2) == 1) begin
                era_b[i] = 1'b1;
                sym_b[i] = 3'($urandom % 8);
            end
            if (mode == 3) begin
                era_a[i] = 1'b1; era_b[i] = 1'b1;
                sym_a[i] = 3'($urandom % 8);
                sym_b[i] = 3'($urandom % 8);
            end
            expct[i] = (mode == 3) ? 1'b0 : msg[i];
        end
        apply_reset();
        sent = 0; got = 0; errs = 0; stall_bad = 0; first_at = -1; cyc = 0; first_bad = -1;
        while ((sent < n || got < n - DEPTH) && cyc < 4 * n + 200) begin
            @(negedge clk);
            cyc++;
            in_valid = sent < n;
            if (sent < n) begin
                in_soft_a  = sym_a[sent];
                in_soft_b  = sym_b[sent];
                in_erase_a = era_a[sent];
                in_erase_b = era_b[sent];
            end
            out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
            #1;
            if (out_valid && !out_ready && in_ready) stall_bad++;
            if (out_valid && first_at < 0) first_at = sent;
            if (out_valid && out_ready) begin
                if (got >= n - DEPTH || out_bit !== expct[got]) begin
                    errs++;
                    if (first_bad < 0) first_bad = got;
                end
                got++;
            end
            if (in_valid && in_ready) sent++;
        end
        check(cyc < 4 * n + 200, req, "case finished in time", cyc, 4 * n + 200);
        check(errs == 0, req, $sformatf("decoded mismatches (first at %0d)", first_bad), errs, 0);
        check(got == n - DEPTH, req, "decoded bit count", got, n - DEPTH);
        if (bp) check(stall_bad == 0, "R7", "in_ready high while output stalled", stall_bad, 0);
        // R8: no further output without input
        in_valid = 1'b0;
        out_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            #1;
            if (out_valid) got++;
        end
        check(got == n - DEPTH, "R8", "no output once input stops", got, n - DEPTH);
        if (mode == 0) check(first_at == DEPTH + 1, "R8", "pairs accepted at first output",
                             first_at, DEPTH + 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(20240611);
        apply_reset();
        @(negedge clk);
        #1;
        // R6: reset state
        check(out_valid == 1'b0, "R6", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R6", "in_ready after reset with out_ready low", int'(in_ready), 1);

        run_case("R1", 300, 0, 1'b0);   // clean random, also R8 latency
        run_case("R1", 120, 4, 1'b0);   // all zeros
        run_case("R1", 120, 5, 1'b0);   // all ones from the zero state, R6 start state
        run_case("R2", 400, 1, 1'b0);   // weak soft values with inverted symbols
        run_case("R3", 400, 2, 1'b0);   // punctured, garbage in erased slots
        run_case("R5", 150, 3, 1'b0);   // all erased: both tie rules give zeros
        run_case("R4", 2000, 1, 1'b0);  // long noisy run forces normalisation
        run_case("R7", 300, 0, 1'b1);   // random sink backpressure

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule